// File: doc/BRIEF.md
# Privilege Mode and Banked Stack-Pointer Controller

This block keeps track of three things for a small processor core. The first is whether the core is running ordinary code (thread mode) or an exception handler (handler mode). The second is whether it runs at privileged or user level. The third is which of two banked stack pointers is visible. Only one pointer can be seen at a time: a main pointer and a process pointer. An exception handler always uses the main pointer. Thread code uses whichever pointer the control value selects. Every stack-pointer write is forced to a 4-byte boundary.

Privilege can only go up through an exception. A user-level thread that tries to clear its user bit through a control write is refused, and a one-cycle flag reports the attempt. A privileged handler may rewrite the control value, and the new thread privilege applies once the core is back in thread mode. Nested exceptions are counted. Only the return that brings the count back to zero leaves handler mode.

The block has no data stream, so there is no valid/ready handshake. Every input is a single-cycle strobe or a write enable that is sampled on the rising clock edge. Every output is a plain level driven from registers and changes only after a clock edge.

Top module: `priv_sp_ctrl`

## Requirements
- R1: After reset the block is in thread mode at privileged level, the control value is 00, both stack pointers hold 0, the main pointer is selected and the illegal flag is low.
- R2: A stack-pointer write stores the written value with bits [1:0] cleared.
- R3: The process pointer is active exactly when the block is in thread mode with control bit 1 set. A write goes only to the active pointer, as selected before the clock edge.
- R4: In handler mode the level is privileged and the main pointer is active.
- R5: In privileged thread mode a control write updates both control bits (bit 0 = user level, bit 1 = process pointer), and the change is visible after the next edge.
- R6: In user-level thread mode a control write leaves the control value unchanged.
- R7: The illegal flag is high for one cycle after a user-level thread control write whose bit 0 is 0.
- R8: An exception entry switches to handler mode and raises the nesting depth by one. An entry made at depth MAX_NEST (7) is ignored.
- R9: An exception return lowers the depth by one. Thread mode resumes only when the depth reaches zero, with privilege taken again from control bit 0. A return at depth zero is ignored.
- R10: An entry and a return in the same cycle act as an entry alone. A control write in a cycle that has an entry or a return strobe is dropped.
- R11: A control write made in handler mode is accepted and decides the thread privilege and thread pointer after the final return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_entry | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| ctrl_wr_en | input | 1 | Control write enable |
| ctrl_wr_data | input | 2 | Control write value: bit 0 user level, bit 1 process pointer |
| sp_wr_en | input | 1 | Active stack-pointer write enable |
| sp_wr_data | input | SP_W | Stack-pointer write value |
| mode_handler | output | 1 | 1 = handler mode, 0 = thread mode |
| priv_user | output | 1 | 1 = user level, 0 = privileged |
| ctrl_o | output | 2 | Current control value |
| sp_is_proc | output | 1 | 1 = process pointer active |
| sp_active | output | SP_W | Value of the active stack pointer |
| illegal_wr | output | 1 | One-cycle flag for a refused privilege raise |

## Verification
Directed sequences walk the whole privilege cycle. The core drops to user level, tries to raise itself back (which must be refused and flagged), and then repeats the same write without the raise (which must be refused silently). It then enters an exception, nests further, and returns. One pass returns to user level and another returns privileged after the handler's grant, which separates restored state from state written inside the handler. Separate sequences fill the nesting counter to its limit and then go one entry past it, and issue a return at depth zero. Other sequences put two strobes in the same cycle to show the priority order. Unaligned pointer writes in each mode show both the alignment and which pointer receives the write. A long pseudo-random run is then compared every cycle against a behavioural model.

// File: rtl/priv_pkg.sv
package priv_pkg;
  typedef struct packed {
    logic spsel;
    logic npriv;
  } ctrl_t;

  localparam int unsigned NUM_SP  = 2;
  localparam int unsigned SP_MAIN = 0;
  localparam int unsigned SP_PROC = 1;
endpackage

// File: rtl/priv_nest_ctr.sv
module priv_nest_ctr #(
  parameter int unsigned MAX_NEST = 7,
  localparam int unsigned DEPTH_W = $clog2(MAX_NEST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_entry,
  input  logic               exc_return,
  output logic [DEPTH_W-1:0] depth,
  output logic               in_handler
);
  localparam logic [DEPTH_W-1:0] DEPTH_MAX = DEPTH_W'(MAX_NEST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
    end else if (exc_entry) begin
      if (depth != DEPTH_MAX) depth <= depth + 1'b1;
    end else if (exc_return && depth != '0) begin
      depth <= depth - 1'b1;
    end
  end

  assign in_handler = (depth != '0);

  p_entry_handler_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> in_handler);

  p_last_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_entry && depth == DEPTH_W'(1)) |=> !in_handler);

  p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_entry && depth == DEPTH_MAX) |=> $stable(depth));
endmodule

// File: rtl/priv_ctrl_reg.sv
module priv_ctrl_reg
  import priv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_handler,
  input  logic  strobe_busy,
  input  logic  wr_en,
  input  ctrl_t wr_data,
  output ctrl_t ctrl_q,
  output logic  priv_user,
  output logic  illegal_q
);
  logic user_lvl;
  logic accept;
  logic raise_try;

  assign user_lvl  = !in_handler && ctrl_q.npriv;
  assign accept    = wr_en && !strobe_busy && !user_lvl;
  assign raise_try = wr_en && user_lvl && !wr_data.npriv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= raise_try;
      if (accept) ctrl_q <= wr_data;
    end
  end

  assign priv_user = user_lvl;

  p_user_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_handler && ctrl_q.npriv) |=> $stable(ctrl_q));

  p_illegal_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_q |-> $past(wr_en));

  p_handler_priv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_handler |-> !priv_user);
endmodule

// File: rtl/priv_sp_bank.sv
module priv_sp_bank
  import priv_pkg::*;
#(
  parameter int unsigned SP_W       = 32,
  parameter int unsigned ALIGN_BITS = 2,
  localparam logic [SP_W-1:0] ALIGN_MASK = ~SP_W'((1 << ALIGN_BITS) - 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_proc,
  input  logic            wr_en,
  input  logic [SP_W-1:0] wr_data,
  output logic [SP_W-1:0] active
);
  logic [SP_W-1:0] sp_q [NUM_SP];

  for (genvar i = 0; i < NUM_SP; i++) begin : g_bank
    logic hit;
    assign hit = wr_en && (sel_proc == (i == SP_PROC));
    always_ff @(posedge clk) begin
      if (!rst_n)   sp_q[i] <= '0;
      else if (hit) sp_q[i] <= wr_data & ALIGN_MASK;
    end
  end

  assign active = sel_proc ? sp_q[SP_PROC] : sp_q[SP_MAIN];

  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active[ALIGN_BITS-1:0] == '0);

  p_other_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_proc) |=> $stable(sp_q[SP_PROC]));
endmodule

// File: rtl/priv_sp_ctrl.sv
module priv_sp_ctrl
  import priv_pkg::*;
#(
  parameter int unsigned SP_W     = 32,
  parameter int unsigned MAX_NEST = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_entry,
  input  logic            exc_return,
  input  logic            ctrl_wr_en,
  input  logic [1:0]      ctrl_wr_data,
  input  logic            sp_wr_en,
  input  logic [SP_W-1:0] sp_wr_data,
  output logic            mode_handler,
  output logic            priv_user,
  output logic [1:0]      ctrl_o,
  output logic            sp_is_proc,
  output logic [SP_W-1:0] sp_active,
  output logic            illegal_wr
);
  localparam int unsigned DEPTH_W = $clog2(MAX_NEST + 1);

  logic [DEPTH_W-1:0] depth;
  logic               in_handler;
  ctrl_t              ctrl_q;

  priv_nest_ctr #(.MAX_NEST(MAX_NEST)) u_nest (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_entry  (exc_entry),
    .exc_return (exc_return),
    .depth      (depth),
    .in_handler (in_handler)
  );

  priv_ctrl_reg u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_handler  (in_handler),
    .strobe_busy (exc_entry || exc_return),
    .wr_en       (ctrl_wr_en),
    .wr_data     (ctrl_t'(ctrl_wr_data)),
    .ctrl_q      (ctrl_q),
    .priv_user   (priv_user),
    .illegal_q   (illegal_wr)
  );

  assign sp_is_proc = !in_handler && ctrl_q.spsel;

  priv_sp_bank #(.SP_W(SP_W), .ALIGN_BITS(2)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_proc (sp_is_proc),
    .wr_en    (sp_wr_en),
    .wr_data  (sp_wr_data),
    .active   (sp_active)
  );

  assign mode_handler = in_handler;
  assign ctrl_o       = ctrl_q;

  p_handler_main_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_handler |-> !sp_is_proc);

  p_entry_priv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> (mode_handler && !priv_user));
endmodule

// File: tb/tb_priv_sp_ctrl.sv
module tb_priv_sp_ctrl;
  localparam int SP_W = 32;
  localparam int MAXN = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_entry = 0, exc_return = 0, ctrl_wr_en = 0, sp_wr_en = 0;
  logic [1:0] ctrl_wr_data = '0;
  logic [SP_W-1:0] sp_wr_data = '0;
  logic mode_handler, priv_user, sp_is_proc, illegal_wr;
  logic [1:0] ctrl_o;
  logic [SP_W-1:0] sp_active;

  int checks = 0;
  int fails = 0;

  // reference model state
  int m_depth = 0;
  bit m_npriv = 0, m_spsel = 0, m_ill = 0;
  logic [SP_W-1:0] m_sp [2] = '{default: '0};

  always #5 clk = ~clk;

  priv_sp_ctrl #(.SP_W(SP_W), .MAX_NEST(MAXN)) dut (
    .clk(clk), .rst_n(rst_n), .exc_entry(exc_entry), .exc_return(exc_return),
    .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data), .sp_wr_en(sp_wr_en),
    .sp_wr_data(sp_wr_data), .mode_handler(mode_handler), .priv_user(priv_user),
    .ctrl_o(ctrl_o), .sp_is_proc(sp_is_proc), .sp_active(sp_active),
    .illegal_wr(illegal_wr)
  );

  task automatic chk(input string req, input logic [SP_W-1:0] act, input logic [SP_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(input string ctx);
    bit hnd, proc;
    hnd  = (m_depth != 0);
    proc = !hnd && m_spsel;
    chk({ctx, " R8/R9 mode"}, SP_W'(mode_handler), SP_W'(hnd));
    chk({ctx, " R4/R6 priv"}, SP_W'(priv_user), SP_W'(!hnd && m_npriv));
    chk({ctx, " R5/R6/R11 ctrl"}, SP_W'(ctrl_o), SP_W'({m_spsel, m_npriv}));
    chk({ctx, " R3 sel"}, SP_W'(sp_is_proc), SP_W'(proc));
    chk({ctx, " R2/R3 sp"}, sp_active, m_sp[proc]);
    chk({ctx, " R7 illegal"}, SP_W'(illegal_wr), SP_W'(m_ill));
  endtask

  // compare previous result, then drive a new cycle and advance the model
  task automatic step(input string ctx, input bit ee, input bit er,
                      input bit cw, input logic [1:0] cd,
                      input bit sw, input logic [SP_W-1:0] sd);
    bit user, sel;
    @(negedge clk);
    compare(ctx);
    exc_entry = ee; exc_return = er; ctrl_wr_en = cw; ctrl_wr_data = cd;
    sp_wr_en = sw; sp_wr_data = sd;
    user = (m_depth == 0) && m_npriv;
    sel  = (m_depth == 0) && m_spsel;
    m_ill = cw && user && !cd[0];
    if (sw) m_sp[sel] = sd & ~SP_W'(3);
    if (cw && !(ee || er) && !user) begin m_npriv = cd[0]; m_spsel = cd[1]; end
    if (ee) begin if (m_depth < MAXN) m_depth++; end
    else if (er && m_depth > 0) m_depth--;
  endtask

  task automatic idle(input string ctx);
    step(ctx, 0, 0, 0, 2'b00, 0, '0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset");
    // R2 unaligned write to main pointer
    step("R2 main", 0, 0, 0, 2'b00, 1, 32'h2000_0FFF);
    idle("R2 main");
    // R5 privileged select of process pointer
    step("R5 spsel", 0, 0, 1, 2'b10, 0, '0);
    step("R3 proc wr", 0, 0, 0, 2'b00, 1, 32'h1000_0123);
    idle("R3 proc wr");
    // R5 drop to user
    step("R5 to user", 0, 0, 1, 2'b11, 0, '0);
    idle("R5 to user");
    // R6/R7 raise attempt, then non-raising write
    step("R7 raise", 0, 0, 1, 2'b00, 0, '0);
    step("R6 silent", 0, 0, 1, 2'b01, 0, '0);
    idle("R6 silent");
    // R8 entry, handler uses main
    step("R8 entry", 1, 0, 0, 2'b00, 0, '0);
    step("R4 msp wr", 0, 0, 0, 2'b00, 1, 32'h2000_0802);
    step("R8 nest", 1, 0, 0, 2'b00, 0, '0);
    step("R9 ret1", 0, 1, 0, 2'b00, 0, '0);
    idle("R9 still handler");
    step("R9 ret2", 0, 1, 0, 2'b00, 0, '0);
    idle("R9 back user");
    // R11 handler grants privilege
    step("R11 entry", 1, 0, 0, 2'b00, 0, '0);
    step("R11 grant", 0, 0, 1, 2'b00, 0, '0);
    step("R11 ret", 0, 1, 0, 2'b00, 0, '0);
    idle("R11 privileged");
    // R8 saturation and R9 floor
    for (int i = 0; i < MAXN + 2; i++) step("R8 sat", 1, 0, 0, 2'b00, 0, '0);
    for (int i = 0; i < MAXN + 2; i++) step("R9 floor", 0, 1, 0, 2'b00, 0, '0);
    idle("R9 floor");
    // R10 priorities
    step("R10 both", 1, 1, 0, 2'b00, 0, '0);
    step("R10 ret+ctrl", 0, 1, 1, 2'b11, 0, '0);
    step("R10 ent+ctrl", 1, 0, 1, 2'b01, 1, 32'h3000_0007);
    step("R10 ret", 0, 1, 0, 2'b00, 0, '0);
    idle("R10 end");
    // R3 write only to selected pointer
    step("R3 main sel", 0, 0, 1, 2'b00, 0, '0);
    step("R3 main wr", 0, 0, 0, 2'b00, 1, 32'hABCD_EF01);
    step("R3 proc sel", 0, 0, 1, 2'b10, 0, '0);
    idle("R3 proc kept");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step("rand", r < 12, (r >= 10 && r < 22), ($urandom_range(0, 3) == 0),
           2'($urandom), ($urandom_range(0, 2) == 0), $urandom);
    end
    idle("final");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule